// File: doc/BRIEF.md
# Multi-word direct-mapped cache

This block is a direct-mapped data cache holding 64 KB. The storage is 4096 lines, and each line carries four 32-bit words. The four words in a line share one tag and one valid flag. A processor issues word reads and writes with a 32-bit byte address. It holds each request until the cache raises ready. A read that finds its line present is answered in the same cycle. A read that misses fetches the whole four-word block from the next memory level, installs it, and then answers from the freshly filled line.

Writes go through to memory every time. A write that finds its line present also updates the cached word. A write that misses leaves the cache untouched. After a synchronous reset the cache walks every line and clears its valid flag, one line per cycle, and it stays not-ready until that walk is over.

Top module: `wordline_cache`

## Requirements
- R1: After reset is released, `cpu_ready` stays low for at least 4096 cycles while every valid flag is cleared. After that, any address read for the first time misses, including lines that were filled before the reset.
- R2: Address fields: bits [1:0] are ignored, bits [3:2] pick the word within the line, bits [15:4] are the line index, and bits [31:16] are the tag. Two addresses that differ only in bits [1:0] return the same word.
- R3: A read whose line is valid and whose stored tag equals address bits [31:16] raises `cpu_ready` and `cpu_hit` in the same cycle as the request, with the selected word on `cpu_rdata`.
- R4: A read miss produces exactly one single-cycle `mem_rd_req` pulse with `mem_rd_addr` = {addr[31:4], 4'b0000}, and `cpu_ready` stays low until the block is installed.
- R5: The refill takes four `mem_rd_valid` beats carrying words 0, 1, 2, 3 in that order. After the last beat, all four words of the block hit with the data delivered.
- R6: The stalled read completes in the first cycle after the last beat with `cpu_hit` high and the requested word.
- R7: Every write raises `mem_wr_req` with `mem_wr_addr` = {addr[31:2], 2'b00} and `mem_wr_data` = `cpu_wdata`. The write completes, with `cpu_ready` high, in the cycle `mem_wr_ack` is high.
- R8: A write hit (`cpu_hit` high during the write) replaces only the addressed word in the line. A following read of it hits with the new value, and the other words keep their values.
- R9: A write miss fills nothing and issues no `mem_rd_req`. A following read of that address misses and returns the written value from memory.
- R10: Two addresses with the same index and different tags evict each other. Addresses with different indexes do not.
- R11: `mem_rd_valid` beats that arrive when no refill is pending are ignored. Cached data and the next refill are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| cpu_req | input | 1 | Request held until completed |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Write data |
| cpu_rdata | output | 32 | Read data, valid when ready on a read |
| cpu_ready | output | 1 | Request completes at this clock edge |
| cpu_hit | output | 1 | Lookup hits in this cycle |
| mem_rd_req | output | 1 | One-cycle block fetch request |
| mem_rd_addr | output | 32 | Block-aligned fetch address |
| mem_rd_valid | input | 1 | Refill beat present |
| mem_rd_data | input | 32 | Refill beat word |
| mem_wr_req | output | 1 | Write-through request |
| mem_wr_addr | output | 32 | Word-aligned write address |
| mem_wr_data | output | 32 | Write-through data |
| mem_wr_ack | input | 1 | Memory accepts the write this cycle |

## Verification
The bench targets the reset sweep by filling lines, resetting again, and requiring a miss on the same address. A design that skipped or shortened the clear would answer from stale lines. Refills are delivered with random gaps, so a fill that latched beats in the wrong slot or finished early returns wrong words for offsets other than the one requested. Stray refill beats are injected while the cache is idle, and a beat counter that advanced on them would close the next fill early with garbage. Same-index conflicts, write hits against neighbouring words, and write misses that must not allocate are all checked too; getting any of these wrong shows up as a wrong hit/miss outcome or stale data.

// File: rtl/wlc_pkg.sv
package wlc_pkg;

   // Controller phases: clearing valid flags, serving lookups,
   // issuing a block fetch, collecting refill beats.
   typedef enum logic [1:0] {
      CS_CLEAR = 2'd0,
      CS_IDLE  = 2'd1,
      CS_ASK   = 2'd2,
      CS_FILL  = 2'd3
   } cache_state_e;

endpackage

// File: rtl/wlc_addr_split.sv
module wlc_addr_split #(
   parameter int ADDR_W = 32,
   parameter int LOW_W  = 4,
   parameter int BYTE_W = 2,
   parameter int OFF_W  = 2,
   parameter int IDX_W  = 12,
   parameter int TAG_W  = 16
) (
   input  logic [ADDR_W-1:0] addr,
   output logic [TAG_W-1:0]  tag,
   output logic [IDX_W-1:0]  idx,
   output logic [OFF_W-1:0]  off
);

   // Byte lanes below BYTE_W are not part of any field: word accesses only.
   assign off = addr[BYTE_W +: OFF_W];
   assign idx = addr[LOW_W +: IDX_W];
   assign tag = addr[ADDR_W-1 -: TAG_W];

endmodule

// File: rtl/wlc_line_store.sv
module wlc_line_store #(
   parameter int LINES  = 4096,
   parameter int WPL    = 4,
   parameter int WORD_W = 32,
   parameter int IDX_W  = 12,
   parameter int OFF_W  = 2,
   parameter int TAG_W  = 16
) (
   input  logic                  clk,
   // lookup (combinational)
   input  logic [IDX_W-1:0]      rd_idx,
   input  logic [OFF_W-1:0]      rd_off,
   output logic                  rd_valid,
   output logic [TAG_W-1:0]      rd_tag,
   output logic [WORD_W-1:0]     rd_word,
   // valid clearing sweep
   input  logic                  clr_en,
   input  logic [IDX_W-1:0]      clr_idx,
   // whole-line install
   input  logic                  fill_en,
   input  logic [IDX_W-1:0]      fill_idx,
   input  logic [TAG_W-1:0]      fill_tag,
   input  logic [WPL*WORD_W-1:0] fill_line,
   // single-word update on write hit
   input  logic                  upd_en,
   input  logic [IDX_W-1:0]      upd_idx,
   input  logic [OFF_W-1:0]      upd_off,
   input  logic [WORD_W-1:0]     upd_word
);

   logic [LINES-1:0] valid_q;
   logic [TAG_W-1:0] tag_q [LINES];
   logic [WORD_W-1:0] lane_rd [WPL];

   // One valid flag and one tag per line, shared by all of its words.
   always_ff @(posedge clk) begin
      if (clr_en) begin
         valid_q[clr_idx] <= 1'b0;
      end else if (fill_en) begin
         valid_q[fill_idx] <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) begin
         tag_q[fill_idx] <= fill_tag;
      end
   end

   // Each word position of a line lives in its own lane array.
   for (genvar w = 0; w < WPL; w++) begin : g_lane
      logic [WORD_W-1:0] lane_q [LINES];

      always_ff @(posedge clk) begin
         if (fill_en) begin
            lane_q[fill_idx] <= fill_line[w*WORD_W +: WORD_W];
         end else if (upd_en && (upd_off == OFF_W'(w))) begin
            lane_q[upd_idx] <= upd_word;
         end
      end

      assign lane_rd[w] = lane_q[rd_idx];
   end

   assign rd_valid = valid_q[rd_idx];
   assign rd_tag   = tag_q[rd_idx];
   assign rd_word  = lane_rd[rd_off];

endmodule

// File: rtl/wlc_ctrl.sv
module wlc_ctrl
   import wlc_pkg::*;
#(
   parameter int LINES = 4096,
   parameter int WPL   = 4,
   parameter int IDX_W = 12,
   parameter int OFF_W = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             lookup,
   input  logic             hit,
   input  logic             beat_valid,
   output logic             idle,
   output logic             clr_en,
   output logic [IDX_W-1:0] clr_idx,
   output logic             miss_start,
   output logic             ask,
   output logic             cap_en,
   output logic             fill_en,
   output logic [OFF_W-1:0] beat_cnt
);

   cache_state_e     st_q;
   logic [IDX_W-1:0] clr_q;
   logic [OFF_W-1:0] beat_q;
   logic             last_beat;

   assign last_beat = (beat_q == OFF_W'(WPL-1));

   always_ff @(posedge clk) begin
      if (rst) begin
         st_q   <= CS_CLEAR;
         clr_q  <= '0;
         beat_q <= '0;
      end else begin
         unique case (st_q)
            CS_CLEAR: begin
               clr_q <= clr_q + 1'b1;
               if (clr_q == IDX_W'(LINES-1)) begin
                  st_q <= CS_IDLE;
               end
            end
            CS_IDLE: begin
               if (lookup && !hit) begin
                  st_q <= CS_ASK;
               end
            end
            CS_ASK: begin
               beat_q <= '0;
               st_q   <= CS_FILL;
            end
            CS_FILL: begin
               if (beat_valid) begin
                  beat_q <= beat_q + 1'b1;
                  if (last_beat) begin
                     st_q <= CS_IDLE;
                  end
               end
            end
            default: st_q <= CS_CLEAR;
         endcase
      end
   end

   assign idle       = (st_q == CS_IDLE);
   assign clr_en     = (st_q == CS_CLEAR);
   assign clr_idx    = clr_q;
   assign miss_start = idle && lookup && !hit;
   assign ask        = (st_q == CS_ASK);
   assign cap_en     = (st_q == CS_FILL) && beat_valid && !last_beat;
   assign fill_en    = (st_q == CS_FILL) && beat_valid && last_beat;
   assign beat_cnt   = beat_q;

endmodule

// File: rtl/wordline_cache.sv
module wordline_cache #(
   parameter int ADDR_W = 32,
   parameter int WORD_W = 32,
   parameter int WPL    = 4,
   parameter int LINES  = 4096
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              cpu_req,
   input  logic              cpu_we,
   input  logic [ADDR_W-1:0] cpu_addr,
   input  logic [WORD_W-1:0] cpu_wdata,
   output logic [WORD_W-1:0] cpu_rdata,
   output logic              cpu_ready,
   output logic              cpu_hit,
   output logic              mem_rd_req,
   output logic [ADDR_W-1:0] mem_rd_addr,
   input  logic              mem_rd_valid,
   input  logic [WORD_W-1:0] mem_rd_data,
   output logic              mem_wr_req,
   output logic [ADDR_W-1:0] mem_wr_addr,
   output logic [WORD_W-1:0] mem_wr_data,
   input  logic              mem_wr_ack
);

   localparam int BYTE_W = $clog2(WORD_W/8);
   localparam int OFF_W  = $clog2(WPL);
   localparam int IDX_W  = $clog2(LINES);
   localparam int LOW_W  = OFF_W + BYTE_W;
   localparam int TAG_W  = ADDR_W - IDX_W - LOW_W;
   localparam int LINE_W = WPL * WORD_W;

   // ---------------- elaboration-time parameter checks ----------------
   if ((WORD_W < 8) || ((WORD_W & (WORD_W-1)) != 0)) begin : g_bad_word
      $error("wordline_cache: WORD_W must be a power of two of at least 8");
   end
   if ((WPL < 2) || ((WPL & (WPL-1)) != 0)) begin : g_bad_wpl
      $error("wordline_cache: WPL must be a power of two of at least 2");
   end
   if ((LINES < 2) || ((LINES & (LINES-1)) != 0)) begin : g_bad_lines
      $error("wordline_cache: LINES must be a power of two of at least 2");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("wordline_cache: address too narrow for the geometry");
   end

   // ---------------- address fields ----------------
   logic [TAG_W-1:0] a_tag;
   logic [IDX_W-1:0] a_idx;
   logic [OFF_W-1:0] a_off;
   logic             unused_byte_lanes;

   wlc_addr_split #(
      .ADDR_W(ADDR_W), .LOW_W(LOW_W), .BYTE_W(BYTE_W),
      .OFF_W(OFF_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
   ) i_split (
      .addr(cpu_addr), .tag(a_tag), .idx(a_idx), .off(a_off)
   );

   assign unused_byte_lanes = ^cpu_addr[BYTE_W-1:0];

   // ---------------- control ----------------
   logic             idle, clr_en, miss_start, ask, cap_en, fill_en;
   logic [IDX_W-1:0] clr_idx;
   logic [OFF_W-1:0] beat_cnt;
   logic             hit_raw;
   logic             s_valid;
   logic [TAG_W-1:0] s_tag;
   logic [WORD_W-1:0] s_word;

   wlc_ctrl #(
      .LINES(LINES), .WPL(WPL), .IDX_W(IDX_W), .OFF_W(OFF_W)
   ) i_ctrl (
      .clk(clk), .rst(rst),
      .lookup(cpu_req && !cpu_we), .hit(hit_raw), .beat_valid(mem_rd_valid),
      .idle(idle), .clr_en(clr_en), .clr_idx(clr_idx),
      .miss_start(miss_start), .ask(ask), .cap_en(cap_en),
      .fill_en(fill_en), .beat_cnt(beat_cnt)
   );

   // ---------------- miss context ----------------
   logic [TAG_W-1:0] m_tag_q;
   logic [IDX_W-1:0] m_idx_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         m_tag_q <= '0;
         m_idx_q <= '0;
      end else if (miss_start) begin
         m_tag_q <= a_tag;
         m_idx_q <= a_idx;
      end
   end

   // ---------------- refill beat assembly ----------------
   logic [LINE_W-1:0] fill_line;

   for (genvar s = 0; s < WPL-1; s++) begin : g_beat
      logic [WORD_W-1:0] slot_q;
      always_ff @(posedge clk) begin
         if (cap_en && (beat_cnt == OFF_W'(s))) begin
            slot_q <= mem_rd_data;
         end
      end
      assign fill_line[s*WORD_W +: WORD_W] = slot_q;
   end
   // The final beat goes straight into the line write.
   assign fill_line[LINE_W-1 -: WORD_W] = mem_rd_data;

   // ---------------- storage ----------------
   logic wr_go;

   wlc_line_store #(
      .LINES(LINES), .WPL(WPL), .WORD_W(WORD_W),
      .IDX_W(IDX_W), .OFF_W(OFF_W), .TAG_W(TAG_W)
   ) i_store (
      .clk(clk),
      .rd_idx(a_idx), .rd_off(a_off),
      .rd_valid(s_valid), .rd_tag(s_tag), .rd_word(s_word),
      .clr_en(clr_en), .clr_idx(clr_idx),
      .fill_en(fill_en), .fill_idx(m_idx_q), .fill_tag(m_tag_q), .fill_line(fill_line),
      .upd_en(wr_go && hit_raw), .upd_idx(a_idx), .upd_off(a_off), .upd_word(cpu_wdata)
   );

   // ---------------- processor side ----------------
   assign hit_raw   = idle && s_valid && (s_tag == a_tag);
   assign cpu_hit   = cpu_req && hit_raw;
   assign cpu_rdata = s_word;
   assign wr_go     = mem_wr_req && mem_wr_ack;
   assign cpu_ready = cpu_we ? wr_go : (cpu_req && hit_raw);

   // ---------------- memory side ----------------
   assign mem_rd_req  = ask;
   assign mem_rd_addr = {m_tag_q, m_idx_q, {LOW_W{1'b0}}};
   assign mem_wr_req  = idle && cpu_req && cpu_we;
   assign mem_wr_addr = {cpu_addr[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
   assign mem_wr_data = cpu_wdata;

endmodule

// File: rtl/wlc_chk.sv
module wlc_chk #(
   parameter int ADDR_W = 32,
   parameter int WPL    = 4,
   parameter int LINES  = 4096,
   parameter int LOW_W  = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              cpu_req,
   input logic              cpu_we,
   input logic [ADDR_W-1:0] cpu_addr,
   input logic              cpu_ready,
   input logic              cpu_hit,
   input logic              mem_rd_req,
   input logic [ADDR_W-1:0] mem_rd_addr,
   input logic              mem_rd_valid,
   input logic              mem_wr_req,
   input logic              mem_wr_ack
);

   localparam int PW = $clog2(WPL) + 1;

   logic [31:0]   since_q;
   logic [PW-1:0] pend_q;

   // Cycles elapsed since reset release, saturating.
   always_ff @(posedge clk) begin
      if (rst) begin
         since_q <= '0;
      end else if (since_q != 32'hFFFF_FFFF) begin
         since_q <= since_q + 32'd1;
      end
   end

   // Refill beats still owed after a fetch request.
   always_ff @(posedge clk) begin
      if (rst) begin
         pend_q <= '0;
      end else if (mem_rd_req) begin
         pend_q <= PW'(WPL);
      end else if (mem_rd_valid && (pend_q != '0)) begin
         pend_q <= pend_q - 1'b1;
      end
   end

   assert_clear_blocks_ready_R1: assert property (@(posedge clk) disable iff (rst)
      (since_q < 32'(LINES)) |-> !cpu_ready);

   assert_fetch_matches_request_R2: assert property (@(posedge clk) disable iff (rst)
      (mem_rd_req && cpu_req) |-> (mem_rd_addr[ADDR_W-1:LOW_W] == cpu_addr[ADDR_W-1:LOW_W]));

   assert_read_ready_is_hit_R3: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && !cpu_we && cpu_ready) |-> cpu_hit);

   assert_fetch_aligned_R4: assert property (@(posedge clk) disable iff (rst)
      mem_rd_req |-> (mem_rd_addr[LOW_W-1:0] == '0));

   assert_fetch_single_pulse_R4: assert property (@(posedge clk) disable iff (rst)
      mem_rd_req |=> !mem_rd_req);

   assert_stall_until_beats_R5: assert property (@(posedge clk) disable iff (rst)
      (pend_q != '0) |-> !cpu_ready);

   assert_no_ready_on_fetch_R6: assert property (@(posedge clk) disable iff (rst)
      mem_rd_req |-> !cpu_ready);

   assert_write_goes_through_R7: assert property (@(posedge clk) disable iff (rst)
      (cpu_req && cpu_we && cpu_ready) |-> (mem_wr_req && mem_wr_ack));

   assert_write_req_only_on_write_R7: assert property (@(posedge clk) disable iff (rst)
      mem_wr_req |-> (cpu_req && cpu_we));

endmodule

bind wordline_cache wlc_chk #(
   .ADDR_W(ADDR_W), .WPL(WPL), .LINES(LINES), .LOW_W(LOW_W)
) i_wlc_chk (
   .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
   .cpu_ready(cpu_ready), .cpu_hit(cpu_hit), .mem_rd_req(mem_rd_req),
   .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
   .mem_wr_req(mem_wr_req), .mem_wr_ack(mem_wr_ack)
);

// File: tb/test_wordline_cache.sv
module test_wordline_cache;

   localparam int CLK_PERIOD = 10;
   localparam int HALF       = CLK_PERIOD / 2;
   localparam int LINES      = 4096;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cpu_req = 1'b0, cpu_we = 1'b0;
   logic [31:0] cpu_addr = '0, cpu_wdata = '0;
   logic [31:0] cpu_rdata;
   logic        cpu_ready, cpu_hit;
   logic        mem_rd_req;
   logic [31:0] mem_rd_addr;
   logic        mem_rd_valid = 1'b0;
   logic [31:0] mem_rd_data = '0;
   logic        mem_wr_req;
   logic [31:0] mem_wr_addr, mem_wr_data;
   logic        mem_wr_ack = 1'b0;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   // Memory model: written words override a computed background pattern.
   logic [31:0] wmem  [int unsigned];
   // Shadow of which tag each index holds (hit/miss prediction only).
   logic [15:0] sh_tag[int];
   int          stray_n = 0;

   always #(HALF) clk = ~clk;

   wordline_cache i_wordline_cache (
      .clk(clk), .rst(rst),
      .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
      .cpu_rdata(cpu_rdata), .cpu_ready(cpu_ready), .cpu_hit(cpu_hit),
      .mem_rd_req(mem_rd_req), .mem_rd_addr(mem_rd_addr),
      .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
      .mem_wr_req(mem_wr_req), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
      .mem_wr_ack(mem_wr_ack)
   );

   function automatic logic [31:0] memval(input logic [29:0] waddr);
      if (wmem.exists(waddr)) return wmem[waddr];
      return ({2'b00, waddr} * 32'h9E37_79B1) ^ 32'hA5C3_0F1E;
   endfunction

   function automatic bit predict_hit(input logic [31:0] a);
      int ix = int'(a[15:4]);
      return sh_tag.exists(ix) && (sh_tag[ix] == a[31:16]);
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // ---------------- memory responder ----------------
   initial begin
      bit          fill_pend = 1'b0;
      logic [29:0] fill_base = '0;
      int          beat = 0;
      int          ack_wait = 0;
      forever begin
         @(negedge clk);
         // write acknowledge, never two cycles in a row
         if (mem_wr_ack) begin
            mem_wr_ack = 1'b0;
         end else if (mem_wr_req) begin
            if (ack_wait == 0) begin
               mem_wr_ack = 1'b1;
               ack_wait = int'($urandom % 3);
            end else begin
               ack_wait--;
            end
         end
         // refill beats with random gaps, or stray beats when idle
         mem_rd_valid = 1'b0;
         if (fill_pend) begin
            if (($urandom % 3) != 0) begin
               mem_rd_valid = 1'b1;
               mem_rd_data  = memval(fill_base + 30'(beat));
               beat++;
               if (beat == 4) fill_pend = 1'b0;
            end
         end else if (stray_n > 0) begin
            mem_rd_valid = 1'b1;
            mem_rd_data  = 32'hDEAD_0000 + 32'(stray_n);
            stray_n--;
         end
         if (mem_rd_req) begin
            fill_pend = 1'b1;
            fill_base = mem_rd_addr[31:2];
            beat = 0;
         end
      end
   end

   // ---------------- one processor access ----------------
   task automatic do_op(input bit we, input logic [31:0] addr, input logic [31:0] wd,
                        output int waited);
      bit pred = predict_hit(addr);
      int rq = 0;
      waited = 0;
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = addr; cpu_wdata = wd;
      forever begin
         #(HALF-1);
         if (mem_rd_req) begin
            rq++;
            chk(mem_rd_addr == {addr[31:4], 4'b0000}, "R4 fetch address", mem_rd_addr,
                {addr[31:4], 4'b0000});
         end
         if (cpu_ready) break;
         waited++;
         @(negedge clk);
      end
      if (!we) begin
         chk((waited == 0) == pred, "R3/R4 hit outcome", 32'(waited == 0), 32'(pred));
         chk(cpu_hit == 1'b1, "R6 hit on completion", 32'(cpu_hit), 32'd1);
         chk(cpu_rdata == memval(addr[31:2]), "R5 read data", cpu_rdata, memval(addr[31:2]));
         chk(rq == (pred ? 0 : 1), "R4 fetch count", 32'(rq), 32'(pred ? 0 : 1));
         if (!pred) begin
            chk(waited >= 5, "R5 four beats before completion", 32'(waited), 32'd5);
            sh_tag[int'(addr[15:4])] = addr[31:16];
         end
      end else begin
         chk(cpu_hit == pred, "R8 write hit flag", 32'(cpu_hit), 32'(pred));
         chk(mem_wr_addr == {addr[31:2], 2'b00}, "R7 write address", mem_wr_addr,
             {addr[31:2], 2'b00});
         chk(mem_wr_data == wd, "R7 write data", mem_wr_data, wd);
         chk(rq == 0, "R9 write never fetches", 32'(rq), 32'd0);
         wmem[addr[31:2]] = wd;
      end
      @(negedge clk);
      cpu_req = 1'b0;
   endtask

   task automatic rd(input logic [31:0] addr);
      int w;
      do_op(1'b0, addr, 32'h0, w);
   endtask

   task automatic wr(input logic [31:0] addr, input logic [31:0] d);
      int w;
      do_op(1'b1, addr, d, w);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      sh_tag.delete();
      repeat (3) @(negedge clk);
      rst = 1'b0;
      #(HALF-1);
      chk(cpu_ready == 1'b0, "R1 not ready after reset", 32'(cpu_ready), 32'd0);
      chk(mem_rd_req == 1'b0, "R1 no fetch after reset", 32'(mem_rd_req), 32'd0);
      chk(mem_wr_req == 1'b0, "R1 no write after reset", 32'(mem_wr_req), 32'd0);
   endtask

   // ---------------- watchdog ----------------
   initial begin
      #(CLK_PERIOD * 150000);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   // ---------------- stimulus ----------------
   localparam logic [31:0] A = 32'h1234_0050;   // tag 1234, index 005
   localparam logic [31:0] C = 32'h5678_0050;   // same index, other tag
   localparam logic [31:0] E = 32'h1234_0060;   // same tag, index 006

   initial begin
      int w;
      void'($urandom(32'd20231210));

      // R1: reset sweep blocks the first request
      do_reset();
      do_op(1'b0, A, 32'h0, w);
      chk(w >= LINES, "R1 clearing sweep length", 32'(w), 32'(LINES));

      // R5: the other three words came with the block
      rd(A + 32'h0); rd(A + 32'h4); rd(A + 32'h8); rd(A + 32'hC);
      // R2: byte offset bits ignored
      rd(A + 32'h7);
      chk(cpu_rdata == memval((A + 32'h4) >> 2), "R2 byte lanes ignored", cpu_rdata,
          memval((A + 32'h4) >> 2));

      // R8: write hit on word 2, neighbours unchanged
      wr(A + 32'h8, 32'hCAFE_F00D);
      rd(A + 32'h8);
      chk(cpu_rdata == 32'hCAFE_F00D, "R8 updated word", cpu_rdata, 32'hCAFE_F00D);
      rd(A + 32'h4);
      rd(A + 32'hC);

      // R9: write miss does not allocate
      wr(32'h0BAD_1230, 32'h1111_2222);
      rd(32'h0BAD_1230);
      chk(cpu_rdata == 32'h1111_2222, "R9 data from memory", cpu_rdata, 32'h1111_2222);

      // R10: same-index conflict evicts, different index does not
      rd(E);
      rd(C);
      rd(A);
      rd(E);

      // R11: stray beats while idle
      stray_n = 2;
      repeat (4) @(negedge clk);
      rd(A + 32'hC);
      rd(32'h7777_0A40);
      rd(32'h7777_0A48);

      // R2: top index and top tag boundary
      rd(32'hFFFF_FFF4);
      rd(32'hFFFF_FFF8);
      rd(32'h0000_FFF0);
      rd(32'hFFFF_FFFC);

      // Constrained random mix over a small address pool
      for (int i = 0; i < 400; i++) begin
         logic [15:0] tg;
         logic [11:0] ix;
         logic [31:0] ad;
         case ($urandom % 4)
            0: tg = 16'h0000;
            1: tg = 16'h0001;
            2: tg = 16'h8000;
            default: tg = 16'hFFFF;
         endcase
         case ($urandom % 6)
            0: ix = 12'd0;
            1: ix = 12'd1;
            2: ix = 12'd2;
            3: ix = 12'd3;
            4: ix = 12'd2048;
            default: ix = 12'd4095;
         endcase
         ad = {tg, ix, 2'($urandom), 2'($urandom)};
         if (($urandom % 3) == 0) wr(ad, $urandom);
         else rd(ad);
      end

      // R1: second reset forgets a line that was cached
      rd(A);
      do_reset();
      do_op(1'b0, A, 32'h0, w);
      chk(w >= LINES, "R1 second sweep length", 32'(w), 32'(LINES));

      finish_up();
   end

endmodule